// File: doc/BRIEF.md
# Microprogram Sequencer Branch Decoder

This block turns a 3-bit sequencer opcode and a condition-fail flag into the control word of a microprogram sequencer. The control word has four parts: a next-address select, enables for three jump-address sources (pipeline field, mapping table, interrupt vector), and controls for a 4-entry return-address stack. Most opcodes have two meanings. The first applies when the condition passes. The second applies when FAIL is set, and in most cases it becomes a jump to the pipeline address.

The decoder is purely combinational. The top module wraps it together with the return stack, the next-address multiplexer and the current-address register. This lets the decoded controls be observed both directly and through the address sequence they produce. Microcode storage lies outside the block. The caller presents the opcode, FAIL and the three candidate addresses in every cycle.

Top module: `useq_branch_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, `addr` becomes 0 and the return stack becomes empty.
- R2: `nsel` encodes 0 = increment, 1 = stack top, 2 = jump, 3 = hold. The value of `nsel` is as follows. Opcode 000 gives 0. Opcode 110 gives 1. Opcodes 010 and 011 give 2. Opcode 100 gives 2. Opcode 101 gives 2. Opcode 001 gives 0 on pass and 2 on fail. Opcode 111 gives 3 on pass and 2 on fail.
- R3: Exactly one of `oe_pl`, `oe_map` and `oe_vec` is high when `nsel` is 2, and none is high otherwise. The vector enable is used for opcode 011 and for opcode 100 on fail. The map enable is used for opcode 100 on pass. Every other jump uses the pipeline enable.
- R4: `stk_clr` is high only for opcode 000. `stk_push` is high only for opcode 101 on pass. `stk_pop` is high only for opcode 110. `stk_en` is high exactly when one of these three is high.
- R5: At each clock edge, `addr` is updated from `nsel`. Increment gives addr+1, wrapping modulo 2^ADDR_W. Jump gives the address of the enabled source. Hold leaves `addr` unchanged.
- R6: A push stores addr+1. A stack-top select loads the most recently pushed entry and pops it, so returns come back in reverse order of the calls, up to 4 levels deep.
- R7: A push while 4 entries are held is ignored by the stack, although its jump still happens. The four entries held before it stay unchanged.
- R8: A stack-top select with an empty stack loads address 0, and the stack stays empty.
- R9: Opcode 000 empties the stack and advances `addr` to addr+1.
- R10: For opcodes 000, 010, 011 and 110, FAIL has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Sequencer opcode |
| fail | input | 1 | Condition failed flag |
| pl_addr | input | ADDR_W | Pipeline-field jump address |
| map_addr | input | ADDR_W | Mapping-table jump address |
| vec_addr | input | ADDR_W | Vector jump address |
| addr | output | ADDR_W | Current microprogram address |
| nsel | output | 2 | Next-address select |
| oe_pl | output | 1 | Pipeline source enable |
| oe_map | output | 1 | Map source enable |
| oe_vec | output | 1 | Vector source enable |
| stk_clr | output | 1 | Stack clear |
| stk_en | output | 1 | Stack enable |
| stk_push | output | 1 | Stack push |
| stk_pop | output | 1 | Stack pop |

## Verification
The assertions take for granted that `op` and `fail` carry defined 0/1 values at every clock edge after reset. This is because the one-hot and exclusivity properties evaluate the decoder's outputs directly. The stimulus drives every input from `$urandom` on the falling edge, so no input is ever undriven or changes near the sampling edge. Directed sequences drive the stack to full and past empty, and drive the address through its wrap point. This way the boundary properties see both their triggering and their quiet sides.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [2:0] {
        OP_WIPE     = 3'd0,
        OP_STEP     = 3'd1,
        OP_GOPL     = 3'd2,
        OP_GOVEC    = 3'd3,
        OP_DISPATCH = 3'd4,
        OP_CALL     = 3'd5,
        OP_RET      = 3'd6,
        OP_AGAIN    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        NS_INC = 2'd0,
        NS_STK = 2'd1,
        NS_JMP = 2'd2,
        NS_CUR = 2'd3
    } nsel_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PL   = 2'd1,
        SRC_MAP  = 2'd2,
        SRC_VEC  = 2'd3
    } src_e;

    typedef struct packed {
        nsel_e sel;
        logic  oe_pl;
        logic  oe_map;
        logic  oe_vec;
        logic  s_clr;
        logic  s_en;
        logic  s_push;
        logic  s_pop;
    } ctl_t;

    function automatic logic [2:0] src_enables(src_e s);
        logic [2:0] e;
        e = 3'b000;
        case (s)
            SRC_PL:  e = 3'b100;
            SRC_MAP: e = 3'b010;
            SRC_VEC: e = 3'b001;
            default: e = 3'b000;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
(
    input  logic [2:0] op,
    input  logic       fail,
    output ctl_t       ctl
);
    src_e src;
    logic clr, push, pop;
    nsel_e sel;

    always_comb begin
        sel  = NS_INC;
        src  = SRC_NONE;
        clr  = 1'b0;
        push = 1'b0;
        pop  = 1'b0;
        case (op_e'(op))
            OP_WIPE: begin
                clr = 1'b1;
            end
            OP_STEP: begin
                if (fail) begin
                    sel = NS_JMP;
                    src = SRC_PL;
                end
            end
            OP_GOPL: begin
                sel = NS_JMP;
                src = SRC_PL;
            end
            OP_GOVEC: begin
                sel = NS_JMP;
                src = SRC_VEC;
            end
            OP_DISPATCH: begin
                sel = NS_JMP;
                src = fail ? SRC_VEC : SRC_MAP;
            end
            OP_CALL: begin
                sel  = NS_JMP;
                src  = SRC_PL;
                push = ~fail;
            end
            OP_RET: begin
                sel = NS_STK;
                pop = 1'b1;
            end
            OP_AGAIN: begin
                if (fail) begin
                    sel = NS_JMP;
                    src = SRC_PL;
                end else begin
                    sel = NS_CUR;
                end
            end
            default: sel = NS_INC;
        endcase
    end

    always_comb begin
        ctl        = '0;
        ctl.sel    = sel;
        {ctl.oe_pl, ctl.oe_map, ctl.oe_vec} = src_enables(src);
        ctl.s_clr  = clr;
        ctl.s_push = push;
        ctl.s_pop  = pop;
        ctl.s_en   = clr | push | pop;
    end

endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  mem [DEPTH];
    logic          full, empty, do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = en & push & ~clr & ~full;
    assign do_pop  = en & pop & ~clr & ~push & ~empty;

    always_ff @(posedge clk) begin
        if (rst || (en && clr)) begin
            cnt <= '0;
        end else if (do_push) begin
            cnt <= cnt + 1'b1;
        end else if (do_pop) begin
            cnt <= cnt - 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (do_push && cnt == CW'(i)) begin
                mem[i] <= din;
            end
        end
    end

    always_comb begin
        top = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (cnt == CW'(j + 1)) top = mem[j];
        end
    end

    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R7
    full_push_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && en && !clr) |=> (cnt == CW'(DEPTH)));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && en && !clr && !push) |=> empty);

    // R8
    empty_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> (top == '0));

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int W = 8
) (
    input  nsel_e        sel,
    input  logic         oe_pl,
    input  logic         oe_map,
    input  logic         oe_vec,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] stk_top,
    input  logic [W-1:0] pl_addr,
    input  logic [W-1:0] map_addr,
    input  logic [W-1:0] vec_addr,
    output logic [W-1:0] nxt,
    output logic [W-1:0] ret
);
    logic [W-1:0] jbus;

    assign ret  = cur + 1'b1;
    assign jbus = ({W{oe_pl}} & pl_addr) | ({W{oe_map}} & map_addr)
                | ({W{oe_vec}} & vec_addr);

    always_comb begin
        case (sel)
            NS_INC:  nxt = ret;
            NS_STK:  nxt = stk_top;
            NS_JMP:  nxt = jbus;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/useq_branch_ctl.sv
module useq_branch_ctl
    import useq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int STK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op,
    input  logic              fail,
    input  logic [ADDR_W-1:0] pl_addr,
    input  logic [ADDR_W-1:0] map_addr,
    input  logic [ADDR_W-1:0] vec_addr,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        nsel,
    output logic              oe_pl,
    output logic              oe_map,
    output logic              oe_vec,
    output logic              stk_clr,
    output logic              stk_en,
    output logic              stk_push,
    output logic              stk_pop
);
    ctl_t              ctl;
    logic [ADDR_W-1:0] addr_q, nxt, ret, top;

    useq_decode u_dec (
        .op   (op),
        .fail (fail),
        .ctl  (ctl)
    );

    useq_stack #(.W(ADDR_W), .DEPTH(STK_DEPTH)) u_stk (
        .clk  (clk),
        .rst  (rst),
        .en   (ctl.s_en),
        .clr  (ctl.s_clr),
        .push (ctl.s_push),
        .pop  (ctl.s_pop),
        .din  (ret),
        .top  (top)
    );

    useq_next #(.W(ADDR_W)) u_nxt (
        .sel      (ctl.sel),
        .oe_pl    (ctl.oe_pl),
        .oe_map   (ctl.oe_map),
        .oe_vec   (ctl.oe_vec),
        .cur      (addr_q),
        .stk_top  (top),
        .pl_addr  (pl_addr),
        .map_addr (map_addr),
        .vec_addr (vec_addr),
        .nxt      (nxt),
        .ret      (ret)
    );

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= nxt;
    end

    assign addr     = addr_q;
    assign nsel     = ctl.sel;
    assign oe_pl    = ctl.oe_pl;
    assign oe_map   = ctl.oe_map;
    assign oe_vec   = ctl.oe_vec;
    assign stk_clr  = ctl.s_clr;
    assign stk_en   = ctl.s_en;
    assign stk_push = ctl.s_push;
    assign stk_pop  = ctl.s_pop;

    // R3
    src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({oe_pl, oe_map, oe_vec}));

    // R3
    jump_has_src_chk: assert property (@(posedge clk) disable iff (rst)
        (nsel == 2'd2) |-> ($countones({oe_pl, oe_map, oe_vec}) == 1));

    // R4
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stk_push && stk_pop) && !(stk_clr && (stk_push || stk_pop)));

    // R5
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (nsel == 2'd3) |=> $stable(addr));

    // R5
    inc_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (nsel == 2'd0) |=> (addr == $past(addr) + 1'b1));

    // R1
    reset_addr_chk: assert property (@(posedge clk)
        rst |=> (addr == '0));

endmodule

// File: tb/useq_branch_ctl_tb.sv
module useq_branch_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op = 3'd0;
    logic       fail = 1'b0;
    logic [7:0] pl_addr = 8'd0, map_addr = 8'd0, vec_addr = 8'd0;
    logic [7:0] addr;
    logic [1:0] nsel;
    logic       oe_pl, oe_map, oe_vec, stk_clr, stk_en, stk_push, stk_pop;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_addr;
    logic [7:0] m_stk [4];
    int         m_cnt;

    always #5 clk = ~clk;

    useq_branch_ctl #(.ADDR_W(8), .STK_DEPTH(4)) dut_i (
        .clk(clk), .rst(rst), .op(op), .fail(fail),
        .pl_addr(pl_addr), .map_addr(map_addr), .vec_addr(vec_addr),
        .addr(addr), .nsel(nsel), .oe_pl(oe_pl), .oe_map(oe_map),
        .oe_vec(oe_vec), .stk_clr(stk_clr), .stk_en(stk_en),
        .stk_push(stk_push), .stk_pop(stk_pop)
    );

    // {sel[1:0], pl, map, vec, clr, en, push, pop}
    function automatic logic [8:0] exp_ctl(input logic [2:0] o, input logic f);
        logic [1:0] s;
        logic [2:0] e;
        logic c, pu, po;
        s = 2'd0; e = 3'b000; c = 0; pu = 0; po = 0;
        case (o)
            3'd0: c = 1;
            3'd1: if (f) begin s = 2'd2; e = 3'b100; end
            3'd2: begin s = 2'd2; e = 3'b100; end
            3'd3: begin s = 2'd2; e = 3'b001; end
            3'd4: begin s = 2'd2; e = f ? 3'b001 : 3'b010; end
            3'd5: begin s = 2'd2; e = 3'b100; pu = ~f; end
            3'd6: begin s = 2'd1; po = 1; end
            default: begin
                if (f) begin s = 2'd2; e = 3'b100; end
                else s = 2'd3;
            end
        endcase
        return {s, e, c, (c | pu | po), pu, po};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] o, input logic f, input logic [7:0] p,
                        input logic [7:0] mp, input logic [7:0] v, input string tag);
        logic [8:0] e;
        logic [7:0] nx, jb;
        string dtag;
        @(negedge clk);
        op = o; fail = f; pl_addr = p; map_addr = mp; vec_addr = v;
        #1;
        e = exp_ctl(o, f);
        dtag = (o == 3'd2 || o == 3'd3 || o == 3'd6 || o == 3'd0) ? "R10" : "R2";
        check(dtag, 32'(nsel), 32'(e[8:7]));
        check("R3", 32'({oe_pl, oe_map, oe_vec}), 32'(e[6:4]));
        check("R4", 32'({stk_clr, stk_en, stk_push, stk_pop}), 32'(e[3:0]));
        jb = (e[6] ? p : 8'd0) | (e[5] ? mp : 8'd0) | (e[4] ? v : 8'd0);
        case (e[8:7])
            2'd0: nx = m_addr + 8'd1;
            2'd1: nx = (m_cnt == 0) ? 8'd0 : m_stk[m_cnt-1];
            2'd2: nx = jb;
            default: nx = m_addr;
        endcase
        if (e[3]) m_cnt = 0;
        else if (e[1]) begin
            if (m_cnt < 4) begin m_stk[m_cnt] = m_addr + 8'd1; m_cnt++; end
        end else if (e[0] && m_cnt > 0) m_cnt--;
        m_addr = nx;
        @(posedge clk);
        #2;
        check(tag, 32'(addr), 32'(m_addr));
    endtask

    initial begin
        #1ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_addr = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #2;
        check("R1", 32'(addr), 32'd0);
        @(negedge clk);
        rst = 0;
        // R8: return with empty stack after reset goes to 0
        step(3'd6, 1'b0, 8'h11, 8'h22, 8'h33, "R8");
        step(3'd6, 1'b1, 8'h11, 8'h22, 8'h33, "R8");
        // R5: wrap
        step(3'd2, 1'b0, 8'hFE, 8'h00, 8'h00, "R5");
        step(3'd1, 1'b0, 8'h00, 8'h00, 8'h00, "R5");
        step(3'd1, 1'b0, 8'h00, 8'h00, 8'h00, "R5");
        step(3'd7, 1'b0, 8'h44, 8'h00, 8'h00, "R5");
        step(3'd4, 1'b0, 8'h01, 8'h5A, 8'hA5, "R5");
        step(3'd4, 1'b1, 8'h01, 8'h5A, 8'hA5, "R5");
        // R6/R7: nest four, fifth push ignored
        step(3'd2, 1'b0, 8'h10, 8'h00, 8'h00, "R5");
        step(3'd5, 1'b0, 8'h20, 8'h00, 8'h00, "R6");
        step(3'd5, 1'b0, 8'h30, 8'h00, 8'h00, "R6");
        step(3'd5, 1'b0, 8'h40, 8'h00, 8'h00, "R6");
        step(3'd5, 1'b0, 8'h50, 8'h00, 8'h00, "R6");
        step(3'd5, 1'b0, 8'h60, 8'h00, 8'h00, "R7");
        for (int k = 0; k < 4; k++) step(3'd6, 1'b0, 8'h77, 8'h00, 8'h00, "R7");
        step(3'd6, 1'b0, 8'h77, 8'h00, 8'h00, "R8");
        // R9: init empties stack
        step(3'd5, 1'b0, 8'h80, 8'h00, 8'h00, "R6");
        step(3'd0, 1'b1, 8'h00, 8'h00, 8'h00, "R9");
        step(3'd6, 1'b0, 8'h00, 8'h00, 8'h00, "R9");
        // fail on call: plain jump, no push
        step(3'd5, 1'b1, 8'h90, 8'h00, 8'h00, "R2");
        step(3'd6, 1'b0, 8'h00, 8'h00, 8'h00, "R8");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            step(3'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
                 8'($urandom), "R6");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule